// File: doc/BRIEF.md
# Bidirectional Gate-Scan Shift Register

This block generates the row-select sequence for an active-matrix panel. A single-cycle start pulse is captured at one end of a long chain of flip-flops and then moves one position per rising clock edge, so that exactly one gate output is active at a time. A direction input chooses the scan order. In forward order the pulse enters through side A and walks from output 0 to the last output. In reverse order it enters through side B and walks the other way.

Each side has its own input pin, output pin and output-enable pin. The side that is not the entry point for the current direction drives a carry pulse to the next cascaded device. This carry is timed on falling clock edges, so the downstream chip samples a clean, full-period pulse on its own rising edge.

Three group-blanking inputs force interleaved thirds of the outputs low. An active-low all-on input forces every output high and overrides the blanking. Neither control disturbs the chain. The outputs are logic-level only; level shifting happens outside the block.

Top module: `gate_scan_driver`

## Requirements
- R1: While `rst_ni` is low, every chain stage and the carry register are cleared. After reset, with `all_on_ni` high and `blank_grp_i` at zero, `gate_o`, `start_a_o` and `start_b_o` are all low.
- R2: With `dir_fwd_i` high, `start_a_i` is sampled on a rising edge. After the k-th rising edge that follows the sampling edge (counting the sampling edge as edge 1), `gate_o[k-1]` is high.
- R3: With `dir_fwd_i` low, `start_b_i` is sampled on a rising edge. After the k-th rising edge (counting the sampling edge as edge 1), `gate_o[STAGES-k]` is high.
- R4: A single start pulse produces exactly one high bit on `gate_o` after every one of the STAGES edges of its scan.
- R5: In forward order, `start_b_oe` is high and `start_a_oe` is low. `start_b_o` rises at the falling edge of clock STAGES and falls at the falling edge of clock STAGES+1.
- R6: In reverse order, `start_a_oe` is high and `start_b_oe` is low. `start_a_o` carries the same pulse, with the same falling-edge timing.
- R7: `blank_grp_i[g]` high forces low every `gate_o[i]` with i mod 3 == g (index 0-based).
- R8: Blanking does not alter the chain. When the blanking is removed, the output pattern is the one the shift position dictates.
- R9: `all_on_ni` low drives every `gate_o` bit high, whatever `blank_grp_i` holds. The chain is kept, and the scan pattern returns when `all_on_ni` goes high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock, rising-edge shift, falling-edge carry |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_fwd_i | input | 1 | 1 = scan from output 0 upward, 0 = scan downward |
| start_a_i | input | 1 | Side A start input (entry in forward order) |
| start_a_o | output | 1 | Side A carry output (used in reverse order) |
| start_a_oe | output | 1 | Side A drive enable |
| start_b_i | input | 1 | Side B start input (entry in reverse order) |
| start_b_o | output | 1 | Side B carry output (used in forward order) |
| start_b_oe | output | 1 | Side B drive enable |
| blank_grp_i | input | 3 | Group blanking, bit g blanks outputs with index mod 3 == g |
| all_on_ni | input | 1 | All outputs high when low, overrides blanking |
| gate_o | output | STAGES | Gate-line select outputs |

## Verification
Blanking and all-on can be asserted in the same cycle, and either can be asserted while the pulse sits in any position. The vector table combines a position with a blank pattern and an all-on level. It checks first that all-on wins over every group bit, and that blanking hides only the group that holds the pulse. It then releases both controls and checks that the pulse is still where the clock count places it. Carry emergence is judged on the falling edges at either end of both scan orders, together with the pin drive-enables.

// File: rtl/gate_scan_pkg.sv
package gate_scan_pkg;

  localparam int unsigned NUM_GROUPS = 3;

  // Group an output belongs to for blanking (0-based index).
  function automatic int unsigned grp_of(input int unsigned idx);
    return idx % NUM_GROUPS;
  endfunction

  // Index of the stage that is last in scan order.
  function automatic int unsigned tail_idx(input logic fwd, input int unsigned n);
    return fwd ? n - 1 : 0;
  endfunction

endpackage

// File: rtl/gate_scan_chain.sv
module gate_scan_chain #(
  parameter int unsigned STAGES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_fwd_i,
  input  logic              entry_a_i,
  input  logic              entry_b_i,
  output logic [STAGES-1:0] stage_q
);

  logic [STAGES-1:0] stage_d;

  // Each stage picks its neighbour toward the entry end.
  for (genvar i = 0; i < STAGES; i++) begin : g_next
    logic from_lo;
    logic from_hi;
    if (i == 0) begin : g_lo_end
      assign from_lo = entry_a_i;
    end else begin : g_lo_mid
      assign from_lo = stage_q[i-1];
    end
    if (i == STAGES - 1) begin : g_hi_end
      assign from_hi = entry_b_i;
    end else begin : g_hi_mid
      assign from_hi = stage_q[i+1];
    end
    assign stage_d[i] = dir_fwd_i ? from_lo : from_hi;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  // R2: forward entry and propagation
  p_entry_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_fwd_i |=> stage_q[0] == $past(entry_a_i));
  p_shift_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_fwd_i |=> stage_q[STAGES-1] == $past(stage_q[STAGES-2]));
  // R3: reverse entry and propagation
  p_entry_rev_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_fwd_i |=> stage_q[STAGES-1] == $past(entry_b_i));
  p_shift_rev_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_fwd_i |=> stage_q[0] == $past(stage_q[1]));

endmodule

// File: rtl/gate_scan_carry.sv
module gate_scan_carry #(
  parameter int unsigned STAGES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_fwd_i,
  input  logic [STAGES-1:0] stage_i,
  output logic              carry_q
);
  import gate_scan_pkg::*;

  localparam int unsigned FWD_TAIL = tail_idx(1'b1, STAGES);
  localparam int unsigned REV_TAIL = tail_idx(1'b0, STAGES);

  logic tail_w;
  assign tail_w = dir_fwd_i ? stage_i[FWD_TAIL] : stage_i[REV_TAIL];

  // Falling-edge capture gives a pulse from fall N to fall N+1.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) carry_q <= 1'b0;
    else         carry_q <= tail_w;
  end

  // R5: carry follows the tail one falling edge later
  p_carry_rise_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    tail_w |=> carry_q);
  p_carry_fall_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !tail_w |=> !carry_q);

endmodule

// File: rtl/gate_scan_gating.sv
module gate_scan_gating #(
  parameter int unsigned STAGES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAGES-1:0] stage_i,
  input  logic [2:0]        blank_grp_i,
  input  logic              all_on_ni,
  output logic [STAGES-1:0] gate_o
);
  import gate_scan_pkg::*;

  logic [STAGES-1:0] grp_mask [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar i = 0; i < STAGES; i++) begin : g_bit
      assign grp_mask[g][i] = (grp_of(i) == g);
    end
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_out
    localparam int unsigned GRP = grp_of(i);
    assign gate_o[i] = !all_on_ni | (stage_i[i] & !blank_grp_i[GRP]);
  end

  // R9: all-on overrides everything
  p_all_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_on_ni |-> &gate_o);

  // R7: a blanked group shows nothing
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    p_blank_grp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blank_grp_i[g] && all_on_ni) |-> ((gate_o & grp_mask[g]) == '0));
  end

endmodule

// File: rtl/gate_scan_driver.sv
module gate_scan_driver #(
  parameter int unsigned STAGES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_fwd_i,
  input  logic              start_a_i,
  output logic              start_a_o,
  output logic              start_a_oe,
  input  logic              start_b_i,
  output logic              start_b_o,
  output logic              start_b_oe,
  input  logic [2:0]        blank_grp_i,
  input  logic              all_on_ni,
  output logic [STAGES-1:0] gate_o
);

  logic [STAGES-1:0] stage_w;
  logic              carry_w;

  gate_scan_chain #(.STAGES(STAGES)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dir_fwd_i (dir_fwd_i),
    .entry_a_i (start_a_i),
    .entry_b_i (start_b_i),
    .stage_q   (stage_w)
  );

  gate_scan_carry #(.STAGES(STAGES)) u_carry (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dir_fwd_i (dir_fwd_i),
    .stage_i   (stage_w),
    .carry_q   (carry_w)
  );

  gate_scan_gating #(.STAGES(STAGES)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stage_i     (stage_w),
    .blank_grp_i (blank_grp_i),
    .all_on_ni   (all_on_ni),
    .gate_o      (gate_o)
  );

  // The non-entry side drives the carry.
  assign start_b_oe = dir_fwd_i;
  assign start_a_oe = !dir_fwd_i;
  assign start_b_o  = dir_fwd_i & carry_w;
  assign start_a_o  = !dir_fwd_i & carry_w;

  // R4: a lone pulse never splits into two active outputs when gating is off
  p_single_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_on_ni && blank_grp_i == 3'b000 && !start_a_i && !start_b_i
      && $countones(stage_w) <= 1) |=> $countones(gate_o) <= 1);

endmodule

// File: tb/gate_scan_driver_tb.sv
module gate_scan_driver_tb;

  localparam int unsigned N     = 256;
  localparam int unsigned CLK_P = 10;
  localparam int unsigned NVEC  = 10;

  // {dir, advance[8:0], blank[2:0], all_on_n}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b1, 9'd1,   3'b000, 1'b1},
    {1'b1, 9'd2,   3'b010, 1'b1},
    {1'b1, 9'd3,   3'b011, 1'b1},
    {1'b1, 9'd256, 3'b001, 1'b1},
    {1'b1, 9'd100, 3'b000, 1'b0},
    {1'b0, 9'd1,   3'b000, 1'b1},
    {1'b0, 9'd2,   3'b100, 1'b1},
    {1'b0, 9'd256, 3'b000, 1'b1},
    {1'b0, 9'd50,  3'b111, 1'b0},
    {1'b1, 9'd128, 3'b110, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         dir;
  logic         sa_i, sb_i;
  logic         sa_o, sa_oe, sb_o, sb_oe;
  logic [2:0]   blank;
  logic         aon_n;
  logic [N-1:0] gate;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  gate_scan_driver #(.STAGES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_fwd_i(dir),
    .start_a_i(sa_i), .start_a_o(sa_o), .start_a_oe(sa_oe),
    .start_b_i(sb_i), .start_b_o(sb_o), .start_b_oe(sb_oe),
    .blank_grp_i(blank), .all_on_ni(aon_n), .gate_o(gate)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic d);
    rst_n = 1'b0; dir = d; sa_i = 0; sb_i = 0; blank = 3'b000; aon_n = 1'b1;
    #(CLK_P); tick(); rst_n = 1'b1; tick();
  endtask

  // Capture a pulse on the entry pin for direction d (edge 1).
  task automatic inject(input logic d);
    if (d) sa_i = 1'b1; else sb_i = 1'b1;
    tick();
    sa_i = 1'b0; sb_i = 1'b0;
  endtask

  function automatic logic [N-1:0] model(input int pos, input logic [2:0] bl, input logic an);
    logic [N-1:0] v = '0;
    if (!an) return '1;
    if (!bl[pos % 3]) v[pos] = 1'b1;
    return v;
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset(1'b1);
    chk("R1 gate", gate, '0);
    chk("R1 carry", {{(N-2){1'b0}}, sa_o, sb_o}, '0);

    // Vector walk: R2, R3, R7, R8, R9
    for (int v = 0; v < NVEC; v++) begin
      logic       d;
      int         adv, pos;
      logic [2:0] bl;
      logic       an;
      d   = VEC[v][13];
      adv = int'(VEC[v][12:4]);
      bl  = VEC[v][3:1];
      an  = VEC[v][0];
      pos = d ? adv - 1 : int'(N) - adv;
      do_reset(d);
      inject(d);
      for (int k = 1; k < adv; k++) tick();
      blank = bl; aon_n = an; #1;
      chk(d ? "R2/R7/R9 fwd gated" : "R3/R7/R9 rev gated", gate, model(pos, bl, an));
      blank = 3'b000; aon_n = 1'b1; #1;
      chk("R8/R9 kept", gate, model(pos, 3'b000, 1'b1));
    end

    // R4 and R5: forward scan, one-hot per step, carry on side B
    do_reset(1'b1);
    inject(1'b1);
    for (int k = 1; k <= int'(N); k++) begin
      checks++;
      if ($countones(gate) != 1 || gate[k-1] !== 1'b1) begin
        fails++;
        $display("FAIL R4 step %0d act=%h exp=bit %0d", k, gate, k-1);
      end
      if (k < int'(N)) tick();
    end
    chk("R5 carry low before fall N", {{(N-1){1'b0}}, sb_o}, '0);
    chk("R5 pin roles", {{(N-2){1'b0}}, sa_oe, sb_oe}, {{(N-2){1'b0}}, 2'b01});
    @(negedge clk); #1;
    chk("R5 carry high after fall N", {{(N-1){1'b0}}, sb_o}, {{(N-1){1'b0}}, 1'b1});
    tick();
    chk("R5 carry held to fall N+1", {{(N-1){1'b0}}, sb_o}, {{(N-1){1'b0}}, 1'b1});
    @(negedge clk); #1;
    chk("R5 carry low after fall N+1", {{(N-1){1'b0}}, sb_o}, '0);

    // R6: reverse scan carry on side A
    do_reset(1'b0);
    inject(1'b0);
    for (int k = 1; k < int'(N); k++) tick();
    chk("R6 last output", gate, {{(N-1){1'b0}}, 1'b1});
    chk("R6 carry low before fall N", {{(N-1){1'b0}}, sa_o}, '0);
    chk("R6 pin roles", {{(N-2){1'b0}}, sa_oe, sb_oe}, {{(N-2){1'b0}}, 2'b10});
    @(negedge clk); #1;
    chk("R6 carry high after fall N", {{(N-1){1'b0}}, sa_o}, {{(N-1){1'b0}}, 1'b1});
    @(negedge clk); #1;
    chk("R6 carry low after fall N+1", {{(N-1){1'b0}}, sa_o}, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule